// File: doc/BRIEF.md
# Program Counter Next-Address Unit

This block works out the next value of a 15-bit program counter. It is given the current program counter, a mode code, the instruction length, the address or offset field of the instruction, and the accumulator. It then produces the address where execution continues. Sequential flow and three transfer modes finish in one cycle: a short signed relative jump, a 12-bit absolute jump that stays inside the current 4K segment, and a 15-bit long jump.

Two modes need program memory before the target is known. The accumulator-indexed indirect jump reads one byte from a table inside the current 256-byte page, and that byte becomes the low byte of the target. The interrupt vector mode reads a two-byte vector from an even/odd address pair. During these modes the unit drives read requests to a synchronous program memory and holds `busy` until the final address is ready.

A command is given by pulsing `start` while the unit is idle. The result appears on `pc_next`, qualified by a one-cycle `pc_valid` pulse. The call stack, instruction decode and the memory array sit outside this block.

Top module: `pc_next_unit`

## Requirements
- R1: After reset, `pc_valid`, `busy` and `mem_req` are 0 and `pc_next` is 0.
- R2: Sequential mode (code 0, and also the unused codes 6 and 7) gives `pc_cur + ilen` modulo 2^15, where `ilen` is 1 to 3. `pc_valid` is 1 in the cycle after the `start` edge.
- R3: Relative mode (code 1) gives `pc_cur + ilen + d` modulo 2^15, where d is `field[5:0]` read as a signed 6-bit value. With `ilen`=1 the reach from the current address is -31 to +32, and 4K segment boundaries may be crossed. The result is ready one cycle after `start`.
- R4: Absolute mode (code 2) gives `{pc_cur[14:12], field[11:0]}`, ready one cycle after `start`.
- R5: Long mode (code 3) gives `field[14:0]`, ready one cycle after `start`.
- R6: Indirect mode (code 4) issues exactly one read at `{pc_cur[14:8], acc}`. The result is `{pc_cur[14:8], byte}`, and `pc_valid` rises three cycles after the `start` edge.
- R7: Vector mode (code 5) reads `{field[14:1],0}` and then the next odd address. The first byte is the high byte. The result is `{high[6:0], low}` (bit 7 of the high byte is dropped), and `pc_valid` rises four cycles after the `start` edge.
- R8: `busy` is 1 from the cycle after a multi-step `start` until the cycle in which `pc_valid` rises. A `start` seen while `busy` is 1 is ignored and produces no result.
- R9: `mem_req` is raised only by the indirect and vector modes, and only while `busy` is 1. Memory takes `mem_addr` at an edge where `mem_req` is 1 and returns the byte on `mem_data` before the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a next-address computation |
| mode | input | 3 | Mode code (0 seq, 1 rel, 2 abs, 3 long, 4 indirect, 5 vector) |
| pc_cur | input | 15 | Current program counter |
| ilen | input | 2 | Length of the current instruction in bytes |
| field | input | 15 | Offset, address or vector-address field |
| acc | input | 8 | Accumulator, used as the table index |
| mem_data | input | 8 | Byte returned by program memory |
| mem_req | output | 1 | Program-memory read request |
| mem_addr | output | 15 | Program-memory read address |
| busy | output | 1 | Multi-step computation in progress |
| pc_valid | output | 1 | One-cycle qualifier for `pc_next` |
| pc_next | output | 15 | Computed next program counter |

## Verification
The bench builds the unit with its default parameters: a 15-bit counter, a 12-bit absolute field, a 6-bit displacement and 8-bit memory bytes. With these values the wrap at 0x7FFF, the crossing of a 4K segment by a relative jump, and the dropped top bit of a vector high byte can all be reached with short directed cases. Random operations over the whole address space then exercise every mode against a bench memory whose contents are a function of the address. Each operation is checked for the result value, the latency, `busy`, and the exact list of addresses fetched.

// File: rtl/pc_next_unit.sv
module pc_next_unit #(
  parameter int PC_W   = 15,
  parameter int ABS_W  = 12,
  parameter int DISP_W = 6,
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [LEN_W-1:0]  ilen,
  input  logic [PC_W-1:0]   field,
  input  logic [BYTE_W-1:0] acc,
  input  logic [BYTE_W-1:0] mem_data,
  output logic              mem_req,
  output logic [PC_W-1:0]   mem_addr,
  output logic              busy,
  output logic              pc_valid,
  output logic [PC_W-1:0]   pc_next
);
  localparam int HI_W  = PC_W - BYTE_W;
  localparam int VEC_W = 2 * BYTE_W;
  localparam logic [2:0] M_REL  = 3'd1;
  localparam logic [2:0] M_ABS  = 3'd2;
  localparam logic [2:0] M_LONG = 3'd3;
  localparam logic [2:0] M_IND  = 3'd4;
  localparam logic [2:0] M_VEC  = 3'd5;

  typedef enum logic [2:0] {S_IDLE, S_I1, S_I2, S_V1, S_V2, S_V3} state_t;
  state_t state;

  logic [HI_W-1:0]   hold_hi;
  logic [BYTE_W-1:0] vec_hi;
  logic [PC_W-1:0]   seq_pc, rel_pc, abs_pc, imm_pc;
  logic [VEC_W-1:0]  vec_word;
  logic              go;

  assign go       = start && state == S_IDLE;
  assign seq_pc   = pc_cur + PC_W'(ilen);
  assign rel_pc   = seq_pc + {{(PC_W-DISP_W){field[DISP_W-1]}}, field[DISP_W-1:0]};
  assign abs_pc   = {pc_cur[PC_W-1:ABS_W], field[ABS_W-1:0]};
  assign vec_word = {vec_hi, mem_data};
  assign busy     = state != S_IDLE;

  always_comb begin
    case (mode)
      M_REL:   imm_pc = rel_pc;
      M_ABS:   imm_pc = abs_pc;
      M_LONG:  imm_pc = field;
      default: imm_pc = seq_pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      pc_valid <= 1'b0;
      pc_next  <= '0;
      hold_hi  <= '0;
      vec_hi   <= '0;
    end else begin
      pc_valid <= 1'b0;
      case (state)
        S_IDLE: if (go) begin
          if (mode == M_IND) begin
            mem_addr <= {pc_cur[PC_W-1:BYTE_W], acc};
            hold_hi  <= pc_cur[PC_W-1:BYTE_W];
            mem_req  <= 1'b1;
            state    <= S_I1;
          end else if (mode == M_VEC) begin
            mem_addr <= {field[PC_W-1:1], 1'b0};
            mem_req  <= 1'b1;
            state    <= S_V1;
          end else begin
            pc_next  <= imm_pc;
            pc_valid <= 1'b1;
          end
        end
        S_I1: begin
          mem_req <= 1'b0;
          state   <= S_I2;
        end
        S_I2: begin
          pc_next  <= {hold_hi, mem_data};
          pc_valid <= 1'b1;
          state    <= S_IDLE;
        end
        S_V1: begin
          mem_addr <= mem_addr | PC_W'(1);
          state    <= S_V2;
        end
        S_V2: begin
          vec_hi  <= mem_data;
          mem_req <= 1'b0;
          state   <= S_V3;
        end
        S_V3: begin
          pc_next  <= vec_word[PC_W-1:0];
          pc_valid <= 1'b1;
          state    <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_idle_out_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_abs_keeps_seg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && !$past(busy) && $past(start) && $past(mode) == M_ABS)
      |-> pc_next[PC_W-1:ABS_W] == $past(pc_cur[PC_W-1:ABS_W]));

  p_long_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_valid && !$past(busy) && $past(start) && $past(mode) == M_LONG)
      |-> pc_next == $past(field));

  p_ind_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && $past(mode) == M_IND)
      |-> mem_req && mem_addr == {$past(pc_cur[PC_W-1:BYTE_W]), $past(acc)});

  p_vec_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && $past(mem_req)) |-> mem_addr == ($past(mem_addr) | PC_W'(1)) && mem_addr[0]);

  p_busy_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pc_valid);

  p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);
endmodule

// File: tb/pc_next_unit_test.sv
`timescale 1ns/1ps
module pc_next_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [14:0] pc_cur = '0;
  logic [1:0]  ilen = 2'd1;
  logic [14:0] field = '0;
  logic [7:0]  acc = '0;
  logic [7:0]  mem_data = '0;
  logic        mem_req, busy, pc_valid;
  logic [14:0] mem_addr, pc_next;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int naddr = 0;
  logic [14:0] alog [0:3];

  pc_next_unit uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .pc_cur(pc_cur),
    .ilen(ilen), .field(field), .acc(acc), .mem_data(mem_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .busy(busy),
    .pc_valid(pc_valid), .pc_next(pc_next)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] rom(input logic [14:0] a);
    return a[7:0] ^ (a[14:8] * 8'd29) ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_req) begin
      mem_data <= rom(mem_addr);
      if (naddr < 4) alog[naddr] <= mem_addr;
      naddr <= naddr + 1;
    end
  end

  function automatic logic [14:0] expect_pc(input logic [2:0] m, input logic [14:0] pc,
      input logic [1:0] len, input logic [14:0] f, input logic [7:0] a);
    logic [14:0] s, ev;
    s = pc + 15'(len);
    ev = {f[14:1], 1'b0};
    case (m)
      3'd1: return s + {{9{f[5]}}, f[5:0]};
      3'd2: return {pc[14:12], f[11:0]};
      3'd3: return f;
      3'd4: return {pc[14:8], rom({pc[14:8], a})};
      3'd5: return {rom(ev)[6:0], rom(ev | 15'd1)};
      default: return s;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] m, input logic [14:0] pc, input logic [1:0] len,
                        input logic [14:0] f, input logic [7:0] a, input bit inject);
    int lat, exp_lat, exp_n;
    logic [14:0] exp_pc, ev;
    exp_pc = expect_pc(m, pc, len, f, a);
    exp_lat = (m == 3'd4) ? 3 : (m == 3'd5) ? 4 : 1;
    exp_n = (m == 3'd4) ? 1 : (m == 3'd5) ? 2 : 0;
    ev = {f[14:1], 1'b0};
    @(negedge clk);
    naddr = 0;
    start = 1'b1; mode = m; pc_cur = pc; ilen = len; field = f; acc = a;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    check(busy == (exp_lat > 1), "R8", "busy after start", busy, exp_lat > 1);
    while (!pc_valid && lat < 10) begin
      if (inject && lat == 1) begin
        start = 1'b1; mode = 3'd3; field = ~f; pc_cur = ~pc;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    start = 1'b0;
    check(pc_valid && pc_next == exp_pc, tag_of(m), "next pc", pc_next, exp_pc);
    check(lat == exp_lat, "R8", "latency", lat, exp_lat);
    check(naddr == exp_n, "R9", "fetch count", naddr, exp_n);
    if (m == 3'd4 && naddr >= 1)
      check(alog[0] == {pc[14:8], a}, "R6", "table address", alog[0], {pc[14:8], a});
    if (m == 3'd5 && naddr >= 2) begin
      check(alog[0] == ev, "R7", "vector high address", alog[0], ev);
      check(alog[1] == (ev | 15'd1), "R7", "vector low address", alog[1], ev | 15'd1);
    end
    if (inject) begin
      @(negedge clk);
      check(!pc_valid && !busy, "R8", "start during busy ignored", pc_valid, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [2:0] m;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pc_valid && !busy && !mem_req && pc_next == 0, "R1", "reset state",
          {pc_valid, busy, mem_req}, 0);
    // R2 sequential, wrap and unused codes
    run_op(3'd0, 15'h7FFF, 2'd1, 15'h0, 8'h00, 0);
    run_op(3'd0, 15'h7FFE, 2'd3, 15'h0, 8'h00, 0);
    run_op(3'd6, 15'h1234, 2'd2, 15'h7FFF, 8'h00, 0);
    run_op(3'd7, 15'h0100, 2'd3, 15'h0000, 8'h00, 0);
    // R3 relative limits and segment crossing
    run_op(3'd1, 15'h0100, 2'd1, 15'h0020, 8'h00, 0);
    run_op(3'd1, 15'h0100, 2'd1, 15'h001F, 8'h00, 0);
    run_op(3'd1, 15'h0FFE, 2'd1, 15'h001F, 8'h00, 0);
    run_op(3'd1, 15'h1000, 2'd1, 15'h0020, 8'h00, 0);
    run_op(3'd1, 15'h0000, 2'd1, 15'h0020, 8'h00, 0);
    // R4 absolute keeps segment, R5 long
    run_op(3'd2, 15'h5ABC, 2'd2, 15'h7123, 8'h00, 0);
    run_op(3'd3, 15'h0001, 2'd3, 15'h7FFF, 8'h00, 0);
    // R6 indirect, R7 vector with odd field and high bit dropped
    run_op(3'd4, 15'h7F80, 2'd1, 15'h0000, 8'hFF, 0);
    run_op(3'd5, 15'h0000, 2'd1, 15'h0FF3, 8'h00, 0);
    run_op(3'd5, 15'h0000, 2'd1, 15'h7FFF, 8'h00, 0);
    // R8 start while busy ignored
    run_op(3'd4, 15'h2345, 2'd1, 15'h0000, 8'h10, 1);
    run_op(3'd5, 15'h2345, 2'd1, 15'h0444, 8'h10, 1);
    // back-to-back single-step commands
    run_op(3'd2, 15'h7000, 2'd1, 15'h0FFF, 8'h00, 0);
    run_op(3'd1, 15'h7FFF, 2'd1, 15'h0020, 8'h00, 0);
    for (int i = 0; i < 400; i++) begin
      m = 3'($urandom_range(0, 7));
      run_op(m, 15'($urandom), 2'($urandom_range(1, 3)), 15'($urandom),
             8'($urandom), ($urandom_range(0, 7) == 0));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule